// File: doc/BRIEF.md
# DRAM Self-Refresh Entry/Exit Sequencer

This block moves a low-power DRAM into self-refresh when the host asks it to sleep and returns the device to normal operation when the host asks it to wake. It works alongside a distributed CAS-before-RAS refresh scheduler. It asks that scheduler for one refresh cycle right before the device enters self-refresh and for another right after it leaves. While it holds the strobes, it drives RAS, CAS and WE itself. At all other times it reports that it does not own the pins, and the memory controller drives them.

Entry lowers CAS first and then RAS. RAS then stays low for a minimum time, 100 µs at the default clock. Because of that floor, the device never sees a RAS-low pulse in the range where it is changing mode. A wake request that arrives before the floor has elapsed is remembered and acted on once the floor is reached. At exit, CAS rises a short programmable lead ahead of RAS. A long self-refresh precharge follows before the pins are handed back.

After every exit, the block counts the refresh cycles the scheduler completes. A new sleep request is not accepted until every row has been refreshed again. All durations are given as clock-cycle parameters. The defaults are for a 200 MHz clock.

Top module: `self_refresh_mgr`

## Requirements
- R1: After reset the block does not own the pins. Its strobe outputs are all high, cbr_req and busy are low, awake is high, and rows_ok is high.
- R2: When sleep_req is sampled high in the idle state while rows_ok is high, cbr_req goes high on the next cycle. It stays high, with no strobe activity, until cbr_done is sampled high.
- R3: Entry takes pin ownership and drives cas_n low with ras_n high for exactly CSR_CYC cycles, and only then drives ras_n low. we_n is high at all times.
- R4: ras_n stays low for at least RASS_CYC consecutive cycles in every self-refresh period, so a shorter low pulse is never produced. The default is 20000 cycles, which is 100 µs at 5 ns.
- R5: A wake_req pulse that arrives before the minimum low time is held, and exit starts with exactly RASS_CYC low cycles with CAS low. A wake_req that arrives later starts exit on the cycle after it is sampled.
- R6: At exit, cas_n rises and stays high with ras_n still low for exactly CAS_LEAD_CYC cycles before ras_n rises. The default is 1 cycle, well inside the permitted 50 ns lead.
- R7: After ras_n rises, the block keeps ownership with both strobes high for exactly RPS_CYC cycles, then releases the pins. The default is 22 cycles, which is at least 110 ns.
- R8: On pin release, cbr_req goes high and stays high until cbr_done is sampled. The block then returns to idle, and busy drops on the following cycle.
- R9: Exit clears a row counter, and each cbr_done pulse accepted after that point counts one row, including the one requested after exit. Until ROWS rows have been counted, rows_ok is low and sleep_req is ignored: busy and cbr_req stay low.
- R10: awake is low and busy is high for the whole time the block owns the pins. During the two refresh handshakes, busy is high and awake is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Host request to enter self-refresh (level) |
| wake_req | input | 1 | Host request to leave self-refresh (pulse or level) |
| cbr_done | input | 1 | Scheduler reports one completed CBR refresh cycle |
| cbr_req | output | 1 | Ask the scheduler for one CBR cycle now |
| pins_own | output | 1 | Block is driving the DRAM strobes |
| ras_n | output | 1 | Row strobe, valid while pins_own |
| cas_n | output | 1 | Column strobe, valid while pins_own |
| we_n | output | 1 | Write enable, held high |
| busy | output | 1 | A sleep or wake sequence is in progress |
| awake | output | 1 | Device is not under self-refresh control |
| rows_ok | output | 1 | Every row refreshed since the last exit; sleep allowed |

## Verification
The bench wakes the device both well before and well after the minimum RAS-low time. A design that dropped an early wake, or acted on it at once, would show a RAS-low run other than the floor. A design that ignored the floor would produce a pulse in the forbidden range. Every strobe segment is measured against its expected length, so a wrong CAS lead at exit, a short precharge, or CAS falling after RAS shows up as a length or ordering mismatch. Sleep is also requested during the re-refresh interval, once with the row count one short of full. A gate that is off by one, or that is missing, would start an entry there.

// File: rtl/self_refresh_mgr.sv
module self_refresh_mgr #(
  parameter int ROWS         = 2048,
  parameter int RASS_CYC     = 20000,
  parameter int RPS_CYC      = 22,
  parameter int CSR_CYC      = 1,
  parameter int CAS_LEAD_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic cbr_done,
  output logic cbr_req,
  output logic pins_own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic busy,
  output logic awake,
  output logic rows_ok
);

  localparam int MAXC = (RASS_CYC > RPS_CYC) ? RASS_CYC : RPS_CYC;
  localparam int CW   = $clog2(MAXC + CSR_CYC + CAS_LEAD_CYC + 1);
  localparam int RW   = $clog2(ROWS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_CSR, S_SELF, S_CHS, S_RPS, S_POST
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rows;
  logic          wake_pend;
  logic          floor_hit;
  logic          leave_self;

  assign floor_hit  = (cnt == CW'(RASS_CYC - 1));
  assign leave_self = (st == S_SELF) && floor_hit && (wake_req || wake_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wake_pend <= 1'b0;
      rows      <= RW'(ROWS);
    end else begin
      case (st)
        S_IDLE: if (sleep_req && rows_ok) st <= S_PRE;
        S_PRE: if (cbr_done) begin
          st  <= S_CSR;
          cnt <= '0;
        end
        S_CSR: if (cnt == CW'(CSR_CYC - 1)) begin
          st  <= S_SELF;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_SELF: if (leave_self) begin
          st  <= (CAS_LEAD_CYC == 0) ? S_RPS : S_CHS;
          cnt <= '0;
        end else if (!floor_hit) cnt <= cnt + 1'b1;
        S_CHS: if (cnt == CW'(CAS_LEAD_CYC - 1)) begin
          st  <= S_RPS;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_RPS: if (cnt == CW'(RPS_CYC - 1)) begin
          st  <= S_POST;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_POST: if (cbr_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase

      if (leave_self)
        wake_pend <= 1'b0;
      else if (wake_req && (st == S_PRE || st == S_CSR || st == S_SELF))
        wake_pend <= 1'b1;

      if (st == S_RPS)
        rows <= '0;
      else if (cbr_done && !rows_ok && (st == S_POST || st == S_IDLE))
        rows <= rows + 1'b1;
    end
  end

  assign rows_ok  = (rows == RW'(ROWS));
  assign pins_own = (st == S_CSR) || (st == S_SELF) || (st == S_CHS) || (st == S_RPS);
  assign ras_n    = !((st == S_SELF) || (st == S_CHS));
  assign cas_n    = !((st == S_CSR) || (st == S_SELF));
  assign we_n     = 1'b1;
  assign cbr_req  = (st == S_PRE) || (st == S_POST);
  assign busy     = (st != S_IDLE);
  assign awake    = !pins_own;

endmodule

// File: rtl/sr_mgr_checker.sv
module sr_mgr_checker #(
  parameter int RASS_CYC = 20000,
  parameter int RPS_CYC  = 22
) (
  input logic clk,
  input logic rst_n,
  input logic cbr_done,
  input logic cbr_req,
  input logic pins_own,
  input logic ras_n,
  input logic cas_n,
  input logic busy,
  input logic awake,
  input logic rows_ok
);

  int lowcnt;
  int hicnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt <= 0;
      hicnt  <= 0;
    end else begin
      if (!ras_n) lowcnt <= (lowcnt < RASS_CYC) ? lowcnt + 1 : lowcnt;
      else        lowcnt <= 0;
      if (ras_n && pins_own) hicnt <= (hicnt < RPS_CYC) ? hicnt + 1 : hicnt;
      else                   hicnt <= 0;
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cbr_req && !cbr_done) |=> cbr_req);

  assert_cas_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  assert_min_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lowcnt >= RASS_CYC));

  assert_cas_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

  assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pins_own) |-> (hicnt >= RPS_CYC));

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rows_ok));

  assert_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (!awake && busy));

endmodule

bind self_refresh_mgr sr_mgr_checker #(.RASS_CYC(RASS_CYC), .RPS_CYC(RPS_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cbr_done(cbr_done), .cbr_req(cbr_req),
  .pins_own(pins_own), .ras_n(ras_n), .cas_n(cas_n), .busy(busy),
  .awake(awake), .rows_ok(rows_ok)
);

// File: tb/sim_self_refresh_mgr.sv
`timescale 1ns/1ps
module sim_self_refresh_mgr;
  localparam int ROWS = 16, RASS = 40, RPS = 6, CSR = 2, LEAD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0, cbr_done = 1'b0;
  logic cbr_req, pins_own, ras_n, cas_n, we_n, busy, awake, rows_ok;

  always #2.5 clk = ~clk;

  self_refresh_mgr #(.ROWS(ROWS), .RASS_CYC(RASS), .RPS_CYC(RPS),
                     .CSR_CYC(CSR), .CAS_LEAD_CYC(LEAD)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .cbr_done(cbr_done), .cbr_req(cbr_req), .pins_own(pins_own),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .busy(busy),
    .awake(awake), .rows_ok(rows_ok));

  typedef struct { logic [2:0] v; int len; string tag; } seg_t;
  seg_t exp_q[$];

  int  n_tests = 0, n_fail = 0;
  bit  ended = 1'b0, we_bad = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // monitor: {pins_own, ras_n, cas_n} segments against expected queue
  logic [2:0] prev = 3'b011;
  int         run  = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] cur;
      cur = {pins_own, ras_n, cas_n};
      if (we_n !== 1'b1) we_bad = 1'b1;
      if (cur !== prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected strobe change", int'(cur), int'(prev));
        end else begin
          seg_t e;
          e = exp_q.pop_front();
          chk(e.v == prev, {e.tag, " segment value"}, int'(prev), int'(e.v));
          if (e.len != 0) chk(run == e.len, {e.tag, " segment length"}, run, e.len);
        end
        prev = cur;
        run  = 1;
      end else run++;
    end
  end

  task automatic push(input logic [2:0] v, input int len, input string tag);
    seg_t e;
    e.v = v; e.len = len; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic cbr_pulse();
    @(negedge clk) cbr_done = 1'b1;
    @(negedge clk) cbr_done = 1'b0;
  endtask

  task automatic do_sleep(input int w);
    push(3'b011, 0,             "R2 idle/handshake");
    push(3'b110, CSR,           "R3 cas-before-ras");
    push(3'b100, imax(w+1, RASS), "R5 self-refresh hold");
    push(3'b101, LEAD,          "R6 cas lead");
    push(3'b111, RPS,           "R7 precharge");
    @(negedge clk) sleep_req = 1'b1;
    @(negedge clk);
    chk(cbr_req && busy && awake, "R2 cbr_req after sleep", int'(cbr_req), 1);
    begin
      bit held = 1'b1;
      repeat (3) begin
        @(negedge clk);
        if (!cbr_req || pins_own) held = 1'b0;
      end
      chk(held, "R2 cbr_req held without strobes", int'(held), 1);
    end
    cbr_pulse();
    sleep_req = 1'b0;
    while (ras_n) @(negedge clk);
    chk(!awake && busy && pins_own, "R10 status in self-refresh", int'(awake), 0);
    repeat (w) @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk) wake_req = 1'b0;
    if (w + 1 < RASS)
      chk(!ras_n, "R5 early wake held", int'(ras_n), 0);
    while (!cbr_req) @(negedge clk);
    chk(!pins_own && awake && busy, "R8 post-exit handshake status", int'(pins_own), 0);
    cbr_pulse();
    chk(!busy && awake, "R8 idle after post-exit refresh", int'(busy), 0);
    chk(!rows_ok, "R9 rows_ok cleared by exit", int'(rows_ok), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && !pins_own && !cbr_req && !busy && awake && rows_ok,
        "R1 reset state", int'({ras_n, cas_n, pins_own, cbr_req, busy, awake, rows_ok}),
        int'(7'b1100011));

    do_sleep(5);

    sleep_req = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busy && !cbr_req && !pins_own, "R9 sleep ignored while rows pending", int'(busy), 0);
    repeat (ROWS - 2) cbr_pulse();
    repeat (4) @(negedge clk);
    chk(!rows_ok && !busy && !cbr_req, "R9 one row short still blocked", int'(rows_ok), 0);
    sleep_req = 1'b0;
    cbr_pulse();
    chk(rows_ok, "R9 rows_ok after full refresh", int'(rows_ok), 1);
    cbr_pulse();
    chk(rows_ok && !busy, "R9 extra refresh keeps rows_ok", int'(rows_ok), 1);

    do_sleep(60);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all expected segments seen", exp_q.size(), 0);
    chk(!we_bad, "R3 we_n held high", int'(we_bad), 0);
    wrap_up();
  end
endmodule